// File: doc/BRIEF.md
# Protected Clock Source Switch Controller

This controller selects the system clock from two on-chip oscillators: a fast one (about 16 MHz) and a slow one (about 10 kHz). Software talks to it through a small byte-wide register port on an always-running bus clock. The fast oscillator drives the system clock after reset. A source change is requested by writing a select code. The controller waits until the target oscillator reports stable. It then hands the clock over without glitches: the old clock is gated off on its falling edge, and the new clock is gated on once the enable has been sampled on two of the new clock's own edges.

Changes to the enable and select registers are protected by a two-byte key. The byte 0xAA followed by 0x55, written to the key register, opens a window of four bus cycles. One protected write may land inside that window. A request stays pending, with a busy flag, for as long as its target is not ready. This includes a target that is switched off, in which case the request never completes.

Two state machines do the work. The key sequencer has the states UL_IDLE, UL_ARMED and UL_OPEN:
- UL_IDLE moves to UL_ARMED on key byte 0xAA.
- UL_ARMED moves to UL_OPEN on key byte 0x55, and falls back to UL_IDLE on any other key byte.
- UL_OPEN returns to UL_IDLE after a protected write, when the window expires, or on a key byte other than 0xAA. Key byte 0xAA in UL_OPEN moves to UL_ARMED.

The switch machine has the states SW_IDLE, SW_WAIT_RDY and SW_HANDOFF:
- SW_IDLE moves to SW_WAIT_RDY on an accepted request for the other source.
- SW_WAIT_RDY moves to SW_HANDOFF once the target's ready bit is set.
- SW_HANDOFF moves back to SW_IDLE once the synchronized gate states show only the target gate open.

Top module: `clkswt_ctrl`

## Requirements
- R1: After reset the fast source drives the system clock. The enable register (address 1) reads 0x20: the fast enable in bit 5, with the pending flag in bit 0 clear. Select bits [2:1] of the switch register (address 2) read 00, and both of its ready bits read 0.
- R2: A write to address 1 or 2 is discarded unless 0xAA and then 0x55 were written to address 0, and the write lands within 4 bus cycles after the 0x55. Any key byte other than 0x55 after 0xAA cancels the sequence.
- R3: Select code 00 requests the fast source and code 10 requests the slow source. Codes 01 and 11 are ignored, and so is a code naming the source already in use. The select bits read back the requested source.
- R4: The pending flag (address 1, bit 0) reads 1 from the cycle after an accepted request until the handoff completes, and 0 otherwise.
- R5: A write to the select field while a request is pending is ignored.
- R6: A pending switch stays pending while its target is disabled or not ready, and the system clock keeps running from the old source.
- R7: The fast ready bit (address 2, bit 5) sets 16 fast-oscillator cycles after the fast source is enabled, and reads 0 in the cycle after the source is disabled. The slow ready bit (bit 4) sets 16 slow cycles after reset.
- R8: Clearing the fast enable is blocked while the fast source drives the clock or is the target of a pending switch. The bit stays 1 in that case.
- R9: The two clock gates are never open together, and after a switch the system clock runs at the selected oscillator's rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on bus clock for registers and state machines |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 key, 1 enable, 2 switch |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| fast_osc | input | 1 | Fast oscillator clock |
| slow_osc | input | 1 | Slow oscillator clock |
| fast_osc_en | output | 1 | Run enable to the fast oscillator |
| sys_clk | output | 1 | Glitch-free selected system clock |

## Verification
The checks assume that each oscillator is slower than the bus clock, so a synchronized edge detector sees every one of its edges. They also assume the fast oscillator only toggles while fast_osc_en is high, and that the slow one never stops. The bench models the oscillators with periods of 40 ns and 200 ns against a 10 ns bus clock. It gates the fast model directly from fast_osc_en. It drives register writes only at falling bus-clock edges, so the four-cycle key window can be hit exactly on its last cycle and one cycle past it.

// File: rtl/clkswt_pkg.sv
package clkswt_pkg;
    typedef enum logic [1:0] {SW_IDLE, SW_WAIT_RDY, SW_HANDOFF} sw_state_e;
    typedef enum logic [1:0] {UL_IDLE, UL_ARMED, UL_OPEN} ul_state_e;

    localparam logic [1:0] ADDR_KEY    = 2'd0;
    localparam logic [1:0] ADDR_ENABLE = 2'd1;
    localparam logic [1:0] ADDR_SWITCH = 2'd2;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    localparam logic [1:0] CODE_FAST = 2'b00;
    localparam logic [1:0] CODE_SLOW = 2'b10;
endpackage

// File: rtl/clkswt_sync.sv
module clkswt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    input  logic rst_val,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{rst_val}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clkswt_unlock.sv
module clkswt_unlock
    import clkswt_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       prot_wr,
    output logic       open
);
    localparam int CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] WIN_LOAD = CW'(WINDOW);

    ul_state_e state, state_nx;
    logic [CW-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= UL_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            UL_IDLE:  if (key_wr && key_data == KEY_FIRST) state_nx = UL_ARMED;
            UL_ARMED: if (key_wr) state_nx = (key_data == KEY_SECOND) ? UL_OPEN : UL_IDLE;
            UL_OPEN: begin
                if (key_wr)                          state_nx = (key_data == KEY_FIRST) ? UL_ARMED : UL_IDLE;
                else if (prot_wr || left == CW'(1))  state_nx = UL_IDLE;
            end
            default: state_nx = UL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     left <= '0;
        else if (state_nx == UL_OPEN && state != UL_OPEN) left <= WIN_LOAD;
        else if (state == UL_OPEN && left != '0)        left <= left - CW'(1);
    end

    always_comb open = (state == UL_OPEN);
endmodule

// File: rtl/clkswt_ready.sv
module clkswt_ready #(
    parameter int RDY_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc,
    input  logic en,
    output logic rdy
);
    localparam int CW = $clog2(RDY_CYCLES + 1);
    localparam logic [CW-1:0] CMAX = CW'(RDY_CYCLES);

    logic osc_s, osc_d, rise;
    logic [CW-1:0] cnt;

    clkswt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(osc), .rst_val(1'b0), .q(osc_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) osc_d <= 1'b0;
        else        osc_d <= osc_s;
    end

    assign rise = osc_s & ~osc_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (!en)                cnt <= '0;
        else if (rise && cnt != CMAX) cnt <= cnt + CW'(1);
    end

    assign rdy = en && (cnt == CMAX);
endmodule

// File: rtl/clkswt_gate.sv
module clkswt_gate (
    input  logic rst_n,
    input  logic fast_osc,
    input  logic slow_osc,
    input  logic use_slow,
    output logic fast_on,
    output logic slow_on,
    output logic sys_clk
);
    logic fast_arm, slow_arm;

    always_ff @(posedge fast_osc or negedge rst_n) begin
        if (!rst_n) fast_arm <= 1'b1;
        else        fast_arm <= ~use_slow & ~slow_on;
    end

    always_ff @(negedge fast_osc or negedge rst_n) begin
        if (!rst_n) fast_on <= 1'b1;
        else        fast_on <= fast_arm;
    end

    always_ff @(posedge slow_osc or negedge rst_n) begin
        if (!rst_n) slow_arm <= 1'b0;
        else        slow_arm <= use_slow & ~fast_on;
    end

    always_ff @(negedge slow_osc or negedge rst_n) begin
        if (!rst_n) slow_on <= 1'b0;
        else        slow_on <= slow_arm;
    end

    assign sys_clk = (fast_osc & fast_on) | (slow_osc & slow_on);
endmodule

// File: rtl/clkswt_ctrl.sv
module clkswt_ctrl
    import clkswt_pkg::*;
#(
    parameter int UNLOCK_WIN  = 4,
    parameter int RDY_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       fast_osc,
    input  logic       slow_osc,
    output logic       fast_osc_en,
    output logic       sys_clk
);
    sw_state_e state, state_nx;
    logic fast_en_q, cur_slow, tgt_slow, use_slow;
    logic fast_rdy, slow_rdy, fast_on, slow_on, fast_on_s, slow_on_s;
    logic ul_open, key_wr, prot_wr, en_wr_ok, sw_wr_ok;
    logic code_ok, code_slow, req, tgt_rdy, done, fast_locked;
    logic pending, start_handoff, finish;

    assign key_wr   = wr_en && addr == ADDR_KEY;
    assign prot_wr  = wr_en && (addr == ADDR_ENABLE || addr == ADDR_SWITCH);
    assign en_wr_ok = prot_wr && ul_open && addr == ADDR_ENABLE;
    assign sw_wr_ok = prot_wr && ul_open && addr == ADDR_SWITCH;

    clkswt_unlock #(.WINDOW(UNLOCK_WIN)) u_unlock (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(wdata),
        .prot_wr(prot_wr), .open(ul_open)
    );

    clkswt_ready #(.RDY_CYCLES(RDY_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_rdy_fast (
        .clk(clk), .rst_n(rst_n), .osc(fast_osc), .en(fast_en_q), .rdy(fast_rdy)
    );

    clkswt_ready #(.RDY_CYCLES(RDY_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_rdy_slow (
        .clk(clk), .rst_n(rst_n), .osc(slow_osc), .en(1'b1), .rdy(slow_rdy)
    );

    clkswt_gate u_gate (
        .rst_n(rst_n), .fast_osc(fast_osc), .slow_osc(slow_osc), .use_slow(use_slow),
        .fast_on(fast_on), .slow_on(slow_on), .sys_clk(sys_clk)
    );

    clkswt_sync #(.STAGES(SYNC_STAGES)) u_sync_fon (
        .clk(clk), .rst_n(rst_n), .d(fast_on), .rst_val(1'b1), .q(fast_on_s)
    );

    clkswt_sync #(.STAGES(SYNC_STAGES)) u_sync_son (
        .clk(clk), .rst_n(rst_n), .d(slow_on), .rst_val(1'b0), .q(slow_on_s)
    );

    assign code_ok   = wdata[2:1] == CODE_FAST || wdata[2:1] == CODE_SLOW;
    assign code_slow = wdata[2:1] == CODE_SLOW;
    assign req       = sw_wr_ok && code_ok && state == SW_IDLE && code_slow != cur_slow;
    assign tgt_rdy   = tgt_slow ? slow_rdy : fast_rdy;
    assign done      = tgt_slow ? (slow_on_s & ~fast_on_s) : (fast_on_s & ~slow_on_s);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SW_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SW_IDLE:     if (req)     state_nx = SW_WAIT_RDY;
            SW_WAIT_RDY: if (tgt_rdy) state_nx = SW_HANDOFF;
            SW_HANDOFF:  if (done)    state_nx = SW_IDLE;
            default:                  state_nx = SW_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        pending       = (state != SW_IDLE);
        start_handoff = (state == SW_WAIT_RDY) && tgt_rdy;
        finish        = (state == SW_HANDOFF) && done;
        fast_locked   = !cur_slow || (pending && !tgt_slow);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_slow <= 1'b0;
            use_slow <= 1'b0;
            cur_slow <= 1'b0;
        end else begin
            if (req)           tgt_slow <= code_slow;
            if (start_handoff) use_slow <= tgt_slow;
            if (finish)        cur_slow <= tgt_slow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fast_en_q <= 1'b1;
        else if (en_wr_ok) begin
            if (wdata[5])          fast_en_q <= 1'b1;
            else if (!fast_locked) fast_en_q <= 1'b0;
        end
    end

    assign fast_osc_en = fast_en_q;

    always_comb begin
        unique case (addr)
            ADDR_ENABLE: rdata = {2'b00, fast_en_q, 4'b0000, pending};
            ADDR_SWITCH: rdata = {2'b00, fast_rdy, slow_rdy, 1'b0,
                                  (tgt_slow ? CODE_SLOW : CODE_FAST), 1'b0};
            default:     rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/clkswt_chk.sv
module clkswt_chk (
    input logic clk,
    input logic rst_n,
    input logic fast_en,
    input logic fast_rdy,
    input logic slow_rdy,
    input logic cur_slow,
    input logic tgt_slow,
    input logic use_slow,
    input logic pending,
    input logic ul_open,
    input logic fast_on,
    input logic slow_on
);
    assert_enable_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fast_en) |-> $past(ul_open));

    assert_target_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && $past(pending)) |-> $stable(tgt_slow));

    assert_slow_handoff_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(use_slow) |-> $past(slow_rdy));

    assert_fast_handoff_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(use_slow) |-> $past(fast_rdy));

    assert_ready_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_en |-> !fast_rdy);

    assert_driver_stays_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_slow |-> fast_en);

    assert_gates_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fast_on && slow_on));
endmodule

bind clkswt_ctrl clkswt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fast_en(fast_en_q), .fast_rdy(fast_rdy),
    .slow_rdy(slow_rdy), .cur_slow(cur_slow), .tgt_slow(tgt_slow),
    .use_slow(use_slow), .pending(pending), .ul_open(ul_open),
    .fast_on(fast_on), .slow_on(slow_on)
);

// File: tb/sim_clkswt_ctrl.sv
module sim_clkswt_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       fast_osc = 1'b0;
    logic       slow_osc = 1'b0;
    logic       fast_osc_en;
    logic       sys_clk;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    bit finished = 0;

    clkswt_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .fast_osc(fast_osc), .slow_osc(slow_osc),
        .fast_osc_en(fast_osc_en), .sys_clk(sys_clk)
    );

    always #5 clk = ~clk;
    always begin #20; if (fast_osc_en !== 1'b0) fast_osc = ~fast_osc; end
    always begin #100; slow_osc = ~slow_osc; end
    always @(posedge sys_clk) edges++;

    // {req[3:0], unlock, waddr[1:0], wdata[7:0], raddr[1:0], mask[7:0], exp[7:0]}
    localparam int NV = 6;
    localparam logic [32:0] VEC [NV] = '{
        {4'd2, 1'b0, 2'd1, 8'h00, 2'd1, 8'h21, 8'h20},  // R2 no key: disable dropped
        {4'd8, 1'b1, 2'd1, 8'h00, 2'd1, 8'h21, 8'h20},  // R8 driver cannot be disabled
        {4'd2, 1'b0, 2'd2, 8'h04, 2'd1, 8'h01, 8'h00},  // R2 no key: switch dropped
        {4'd3, 1'b1, 2'd2, 8'h06, 2'd2, 8'h06, 8'h00},  // R3 code 11 ignored
        {4'd3, 1'b1, 2'd2, 8'h02, 2'd1, 8'h01, 8'h00},  // R3 code 01 ignored
        {4'd3, 1'b1, 2'd2, 8'h00, 2'd1, 8'h01, 8'h00}   // R3 same source, no request
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(2'd0, 8'hAA);
        wr(2'd0, 8'h55);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a; #1; v = rdata;
    endtask

    task automatic wait_bit(input logic [1:0] a, input int bitn, input logic val, input int limit);
        logic [7:0] v;
        for (int i = 0; i < limit; i++) begin
            rd(a, v);
            if (v[bitn] == val) break;
            @(negedge clk);
        end
    endtask

    task automatic count_edges(output int n);
        int start;
        start = edges;
        #4000;
        n = edges - start;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        int n;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        rd(2'd1, v); check("R1 enable reg", v, 8'h20);
        rd(2'd2, v); check("R1 switch reg", v, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [32:0] e;
            e = VEC[i];
            if (e[28]) unlock();
            wr(e[27:26], e[25:18]);
            repeat (2) @(negedge clk);
            rd(e[17:16], v);
            check($sformatf("R%0d vector %0d", e[32:29], i), v & e[15:8], e[7:0]);
        end

        wait_bit(2'd2, 4, 1'b1, 3000);
        rd(2'd2, v); check("R7 slow ready", v[4], 1);
        wait_bit(2'd2, 5, 1'b1, 3000);
        rd(2'd2, v); check("R7 fast ready", v[5], 1);
        count_edges(n); check_range("R9 fast rate", n, 95, 105);

        unlock(); wr(2'd2, 8'h04);
        rd(2'd1, v); check("R4 pending set", v[0], 1);
        wait_bit(2'd1, 0, 1'b0, 2000);
        rd(2'd1, v); check("R4 pending clear", v[0], 0);
        rd(2'd2, v); check("R3 slow selected", v & 8'h06, 8'h04);
        count_edges(n); check_range("R9 slow rate", n, 18, 22);

        unlock(); wr(2'd1, 8'h00);
        rd(2'd1, v); check("R8 disable allowed off-source", v & 8'h20, 0);
        rd(2'd2, v); check("R7 fast ready clears", v & 8'h20, 0);

        unlock(); wr(2'd2, 8'h00);
        repeat (3000) @(negedge clk);
        rd(2'd1, v); check("R6 disabled target pending", v[0], 1);
        count_edges(n); check_range("R6 clock stays slow", n, 18, 22);

        unlock(); wr(2'd2, 8'h04);
        rd(2'd2, v); check("R5 select held", v & 8'h06, 8'h00);
        rd(2'd1, v); check("R5 still pending", v[0], 1);

        unlock(); wr(2'd1, 8'h20);
        repeat (5) @(negedge clk);
        rd(2'd2, v); check("R7 fast not ready yet", v & 8'h20, 0);
        wait_bit(2'd1, 0, 1'b0, 3000);
        rd(2'd1, v); check("R6 switch completes after ready", v, 8'h20);
        count_edges(n); check_range("R9 back to fast", n, 95, 105);

        wr(2'd0, 8'hAA); wr(2'd0, 8'h12); wr(2'd0, 8'h55); wr(2'd2, 8'h04);
        rd(2'd1, v); check("R2 broken key", v[0], 0);

        unlock(); repeat (4) @(negedge clk); wr(2'd2, 8'h04);
        rd(2'd1, v); check("R2 window expired", v[0], 0);
        unlock(); repeat (3) @(negedge clk); wr(2'd2, 8'h04);
        rd(2'd1, v); check("R2 last window cycle", v[0], 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #1500000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule